// File: doc/BRIEF.md
# Five-Times Oversampled Serial Bit Recovery

This block recovers a baseband serial bit stream without any analog phase tracking. A local clock runs at five times the nominal bit rate; for example, a 250 MHz clock serves a 50 Mbps line. The raw line first passes through a synchronizer into that clock domain. Every level change seen on the synchronized line re-arms a small down-counter, and the block takes a sample three fast clocks after that change, which places the sample near the middle of the bit.

When the line holds one level for several bits, the counter keeps running on its own. It takes one further sample every five fast clocks after the previous one. Each sample appears as a registered data bit together with a strobe that is high for one clock. Downstream logic collects the strobed bits. Clock generation and word assembly are not part of this block.

Because the timing is rebuilt at every edge, a bit stretched or shortened by one fast clock is still sampled inside its own interval. Nothing has to settle between edges, so the block keeps up with fast jitter on the sampling clock.

Top module: `oversample_cdr`

## Requirements
- R1: While `rst` is high at a rising clock edge, `bit_valid` and `bit_out` are 0 after that edge.
- R2: After reset, `bit_valid` stays 0 until the first level change on `serial_in` reaches the edge detector. An idle low line produces no strobe.
- R3: A level change on `serial_in` that is first captured at rising edge k makes `bit_valid` high for the cycle after rising edge k+5. This delay is two synchronizer stages, one edge compare and the three-clock offset.
- R4: With no further level change, strobes repeat exactly every 5 clocks after the previous strobe.
- R5: A level change that is detected while a free-running sample is pending cancels that sample. The next strobe then follows the change with the R3 latency.
- R6: If a level change is detected in the same cycle as a counter expiry, that sample is still taken and carries the new line level. The next strobe follows 3 clocks later.
- R7: On each strobe, `bit_out` carries the synchronized line level of the sampling cycle. `bit_out` does not change in any cycle in which `bit_valid` is low.
- R8: `bit_valid` is never high in two consecutive cycles. No two strobes are more than 7 clocks apart once strobes have begun.
- R9: A PRBS7 stream at five clocks per bit is recovered without error from the first 1 bit onward. In this stream every edge is displaced by 0 or +1 clock from its nominal place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, five times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Asynchronous serial line |
| bit_out | output | 1 | Recovered bit, held between strobes |
| bit_valid | output | 1 | One-cycle strobe marking a new recovered bit |

## Verification
The bench aims at exact strobe cycles, not only at recovered data. A design with the wrong synchronizer depth or the wrong offset puts the first strobe away from the sixth cycle. A design that lets the free-running counter win over an edge keeps the stale strobe position after the line moves. A design that drops the sample when an edge and an expiry coincide, or reloads from the expiry, loses a bit or places the next strobe five clocks later instead of three. A long jittered PRBS7 run shows that runs of equal bits neither gain nor lose a sample.

// File: rtl/ovs_cdr_pkg.sv
package ovs_cdr_pkg;

  // Width needed to hold a countdown of either reload value.
  function automatic int timer_width(input int period, input int offset);
    int mx;
    mx = (period > offset) ? period : offset;
    return (mx > 2) ? $clog2(mx) : 1;
  endfunction

endpackage

// File: rtl/ovs_line_sync.sv
module ovs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_async,
  output logic line_sync
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= line_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign line_sync = chain[STAGES-1];

endmodule

// File: rtl/ovs_edge_detect.sv
module ovs_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic toggled
);

  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign toggled = level ^ level_q;

endmodule

// File: rtl/ovs_phase_timer.sv
module ovs_phase_timer
  import ovs_cdr_pkg::*;
#(
  parameter int PERIOD = 5,
  parameter int OFFSET = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic realign,
  output logic fire
);

  localparam int W = timer_width(PERIOD, OFFSET);
  localparam logic [W-1:0] EDGE_LOAD = W'(OFFSET - 1);
  localparam logic [W-1:0] RUN_LOAD  = W'(PERIOD - 1);

  logic         armed;
  logic [W-1:0] count;

  assign fire = armed && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      count <= '0;
    end else if (realign) begin
      armed <= 1'b1;
      count <= EDGE_LOAD;
    end else if (fire) begin
      count <= RUN_LOAD;
    end else if (armed) begin
      count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/oversample_cdr.sv
module oversample_cdr #(
  parameter int OSR         = 5,
  parameter int EDGE_OFFSET = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic serial_in,
  output logic bit_out,
  output logic bit_valid
);

  logic line_s;
  logic edge_seen;
  logic take_sample;

  ovs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .line_async (serial_in),
    .line_sync  (line_s)
  );

  ovs_edge_detect u_edge (
    .clk     (clk),
    .rst     (rst),
    .level   (line_s),
    .toggled (edge_seen)
  );

  ovs_phase_timer #(.PERIOD(OSR), .OFFSET(EDGE_OFFSET)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .realign (edge_seen),
    .fire    (take_sample)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
    end else begin
      bit_valid <= take_sample;
      if (take_sample) bit_out <= line_s;
    end
  end

endmodule

// File: rtl/oversample_cdr_chk.sv
module oversample_cdr_chk #(
  parameter int OSR         = 5,
  parameter int EDGE_OFFSET = 3
) (
  input logic clk,
  input logic rst,
  input logic serial_in,
  input logic bit_out,
  input logic bit_valid
);

  localparam int MAX_GAP = OSR + EDGE_OFFSET - 2;
  localparam int GW = $clog2(MAX_GAP + 2) + 1;

  logic          in_q;
  logic          line_moved;
  logic          strobed;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q       <= 1'b0;
      line_moved <= 1'b0;
      strobed    <= 1'b0;
      gap        <= '0;
    end else begin
      in_q <= serial_in;
      if (serial_in != in_q) line_moved <= 1'b1;
      if (bit_valid) begin
        strobed <= 1'b1;
        gap     <= '0;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R2
  strobe_needs_line_change_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> line_moved);

  // R8
  strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);

  // R7
  data_held_between_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> $stable(bit_out));

  // R8
  strobe_spacing_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (strobed && gap == GW'(MAX_GAP)) |-> bit_valid);

endmodule

bind oversample_cdr oversample_cdr_chk #(.OSR(OSR), .EDGE_OFFSET(EDGE_OFFSET)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .serial_in (serial_in),
  .bit_out   (bit_out),
  .bit_valid (bit_valid)
);

// File: tb/tb_oversample_cdr.sv
module tb_oversample_cdr;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serial_in = 1'b0;
  logic bit_out;
  logic bit_valid;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  oversample_cdr dut (
    .clk       (clk),
    .rst       (rst),
    .serial_in (serial_in),
    .bit_out   (bit_out),
    .bit_valid (bit_valid)
  );

  logic vlog [1:32];
  logic dlog [1:32];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    serial_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic capture(input int n);
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      vlog[j] = bit_valid;
      dlog[j] = bit_out;
    end
  endtask

  // Compare a captured window against a strobe pattern (bit j set = strobe at offset j).
  task automatic check_window(input int n, input logic [32:0] want, input string req);
    for (int j = 1; j <= n; j++)
      chk(vlog[j] == want[j], req, vlog[j], want[j]);
  endtask

  task automatic t_reset_idle();
    do_reset();
    chk(bit_valid == 1'b0, "R1 valid", bit_valid, 0);
    chk(bit_out == 1'b0, "R1 data", bit_out, 0);
    capture(30);
    check_window(30, '0, "R2 idle no strobe");
  endtask

  task automatic t_first_and_freerun();
    logic [32:0] w;
    do_reset();
    serial_in = 1'b1;
    capture(16);
    w = '0; w[6] = 1'b1; w[11] = 1'b1; w[16] = 1'b1;
    check_window(5, w, "R3 no early strobe");
    chk(vlog[6] == 1'b1, "R3 first strobe", vlog[6], 1);
    check_window(16, w, "R4 free-run period");
    chk(dlog[6] == 1'b1 && dlog[16] == 1'b1, "R7 sampled level", dlog[16], 1);
    for (int j = 1; j <= 5; j++) chk(dlog[j] == 1'b0, "R7 hold before strobe", dlog[j], 0);
    for (int j = 7; j <= 10; j++) chk(dlog[j] == 1'b1, "R7 hold after strobe", dlog[j], 1);
  endtask

  task automatic t_realign();
    logic [32:0] w;
    do_reset();
    serial_in = 1'b1;
    capture(12);
    serial_in = 1'b0;
    capture(10);
    w = '0; w[6] = 1'b1;
    check_window(10, w, "R5 realign");
    chk(dlog[6] == 1'b0, "R5 new level", dlog[6], 0);
  endtask

  task automatic t_coincide();
    logic [32:0] w;
    do_reset();
    serial_in = 1'b1;
    capture(13);
    serial_in = 1'b0;
    capture(9);
    w = '0; w[3] = 1'b1; w[6] = 1'b1;
    check_window(9, w, "R6 coincident edge");
    chk(dlog[3] == 1'b0, "R6 sample carries new level", dlog[3], 0);
  endtask

  task automatic t_prbs();
    localparam int IDLE = 20;
    localparam int NBITS = 320;
    logic tx [0:NBITS-1];
    logic [6:0] lfsr = 7'h7f;
    int first_one = -1;
    int rx_idx = 0;
    int rx_cnt = 0;
    int bad = 0;
    int d_prev = 0;
    int d_next;
    bit done = 0;
    for (int i = 0; i < NBITS; i++) begin
      if (i < IDLE) tx[i] = 1'b0;
      else begin
        tx[i] = lfsr[6] ^ lfsr[5];
        lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
      end
      if (first_one < 0 && tx[i]) first_one = i;
    end
    do_reset();
    rx_idx = first_one;
    fork
      begin
        for (int i = 0; i < NBITS; i++) begin
          serial_in = tx[i];
          d_next = $urandom_range(1, 0);
          repeat (5 + d_next - d_prev) @(negedge clk);
          d_prev = d_next;
        end
        repeat (10) @(negedge clk);
        done = 1;
      end
      begin
        while (!done) begin
          @(negedge clk);
          if (bit_valid && !done) begin
            logic e;
            e = (rx_idx < NBITS) ? tx[rx_idx] : tx[NBITS-1];
            if (bit_out != e) begin
              bad++;
              chk(1'b0, "R9 stream bit", bit_out, e);
            end
            rx_idx++;
            rx_cnt++;
          end
        end
      end
    join
    chk(bad == 0, "R9 stream errors", bad, 0);
    chk(rx_cnt >= NBITS - first_one, "R9 strobe count", rx_cnt, NBITS - first_one);
  endtask

  initial begin
    t_reset_idle();
    t_first_and_freerun();
    t_realign();
    t_coincide();
    t_prbs();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule